// File: doc/BRIEF.md
# Glitch-Free Dual Clock Switchover

This block chooses one of two unrelated input clocks and fans the chosen clock out to a set of output channels. Each channel presents the clock on a true output and on its inverse. A change of source never puts a shortened pulse on any output. The outgoing clock is first switched off at one of its own falling edges. The output then stays low while the outgoing side confirms that it is off. The incoming clock is added only after a fixed number of its own cycles, again at one of its own falling edges.

Each side of the switch is a small lane clocked by its own source. A lane brings the select, force and power inputs into its own domain and runs a four-state sequence: active, draining, off, waiting. The lanes hand off to each other through the other lane's synchronized "off" flag. A rising edge on the force input lets the incoming lane skip that handshake, so a switch can still finish when the outgoing clock has died. A stuck outgoing clock is then masked out of the output.

Each channel can be parked on its own at a chosen static level. A power-down input drives every output high and freezes both lanes.

Top module: `glitchfree_clk_switch`

## Requirements
- R1: With src_sel = 1 the outputs carry clk_in1, and with src_sel = 0 they carry clk_in2. While src_sel does not change, no output low phase is longer than a half period of the selected clock.
- R2: At most one source is ever gated onto the outputs. A source is removed only at one of its own falling edges, so its last high phase is full width.
- R3: After src_sel changes, the outgoing lane spends exactly one cycle draining and then reports off. The output low gap is at most (SYNC_STAGES+2) periods of the old clock plus (SYNC_STAGES+LOW_CYC+2) periods of the new clock.
- R4: The incoming lane waits exactly LOW_CYC cycles of its own clock after it sees the old lane off. The output low gap is therefore at least LOW_CYC periods of the new clock, and the first high phase of the new clock is full width.
- R5: No output phase is shorter than the shorter of the two input half-periods.
- R6: Without a force, a switch away from a stopped clock does not complete, and the output stays at the stopped level. A rising edge on force_sel completes the switch to the clock named by src_sel and masks the stopped clock. This requires src_sel to have been settled for at least SYNC_STAGES+1 cycles of the new clock.
- R7: With gate[i] = 1, q_true[i] = park_hi and q_comp[i] = ~park_hi, and the other channels keep toggling.
- R8: With pwr_on = 0, every q_true and q_comp output is 1 and neither lane changes state. When pwr_on returns to 1, the outputs resume on the source that was active before power-down.
- R9: With pwr_on = 1 and the channel not gated, q_comp[i] is always the inverse of q_true[i].
- R10: During and after reset, the lane named by src_sel is active and the other lane is off. The selected clock reaches the outputs without any switch sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in1 | input | 1 | Source clock chosen when src_sel = 1 |
| clk_in2 | input | 1 | Source clock chosen when src_sel = 0 |
| rst_n | input | 1 | Active-low reset, sampled synchronously by each lane |
| src_sel | input | 1 | Source select, asynchronous to both clocks |
| force_sel | input | 1 | Rising edge skips the handshake with the outgoing lane |
| pwr_on | input | 1 | Low forces all outputs high and freezes the lanes |
| park_hi | input | 1 | Static level of q_true on a gated channel |
| gate | input | NUM_CH | Per-channel park request, 1 = parked |
| q_true | output | NUM_CH | True clock outputs |
| q_comp | output | NUM_CH | Complementary clock outputs |

## Verification
The lane properties take three things for granted. First, src_sel is steady across reset and changes no faster than a full switch sequence. Second, force_sel is low at reset and rises only after src_sel has settled. Third, both clocks keep toggling while reset is asserted. The stimulus holds reset for many cycles of both clocks and leaves 400 ns between select changes. It raises force only after the outgoing clock has been stopped and src_sel has been steady for 200 ns. The exclusivity property assumes src_sel does not toggle while both lanes claim the output, which happens only in a forced switch; the bench never toggles src_sel during a forced switch.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
// Shared types for the glitch-free clock switch.
// Assumes: nothing; holds only type definitions.
package clksw_pkg;
    // Lane sequence states: drives the gate on, drains it, sits off, waits to engage
    typedef enum logic [1:0] {
        LN_ACTIVE = 2'd0,
        LN_DRAIN  = 2'd1,
        LN_OFF    = 2'd2,
        LN_WAIT   = 2'd3
    } lane_state_e;
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
// Multi-bit, multi-stage synchronizer. Each bit is an independent
// level that is brought into the clk domain.
// Assumes: bits are quasi-static levels; no bus coherency is needed.
// The stages carry no reset, so they hold the true input level as soon
// as a few clocks have passed during reset.
module clksw_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage captures the asynchronous input
            always_ff @(posedge clk) stage_q[s] <= d;
        end else begin : g_next
            // later stages settle metastability
            always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/clksw_lane.sv
`timescale 1ns/1ps
// One side of the switch, clocked by its own source clock.
// It sequences ACTIVE -> DRAIN -> OFF when deselected and
// OFF -> WAIT (LOW_CYC cycles) -> ACTIVE when selected and the peer is off,
// or when a force edge arrives. The gate enable is registered on the
// falling edge, so it only changes while the clock is low.
// Assumes: sel_in is stable while rst_n is low and the clock runs during reset.
module clksw_lane
    import clksw_pkg::*;
#(
    parameter int LOW_CYC     = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit SEL_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_in,
    input  logic force_in,
    input  logic run_in,
    input  logic peer_off_in,
    output logic off_o,
    output logic claim_o,
    output logic en_o
);
    localparam int CW = (LOW_CYC < 2) ? 1 : $clog2(LOW_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(LOW_CYC - 1);

    logic [3:0]  raw_bus;
    logic [3:0]  sync_bus;
    logic        want_s;
    logic        force_s;
    logic        run_s;
    logic        peer_off_s;
    logic        force_d;
    logic        force_rise;
    lane_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic        en_q;

    assign raw_bus = {peer_off_in, run_in, force_in, sel_in};

    clksw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (raw_bus),
        .q   (sync_bus)
    );

    assign want_s     = (sync_bus[0] == SEL_VAL);
    assign force_s    = sync_bus[1];
    assign run_s      = sync_bus[2];
    assign peer_off_s = sync_bus[3];
    assign force_rise = force_s & ~force_d;

    // delay of the synchronized force level for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) force_d <= 1'b0;
        else        force_d <= force_s;
    end

    // lane sequence; frozen while power-down is seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= (sel_in == SEL_VAL) ? LN_ACTIVE : LN_OFF;
            cnt_q   <= '0;
        end else if (run_s) begin
            unique case (state_q)
                LN_ACTIVE: if (!want_s) state_q <= LN_DRAIN;
                LN_DRAIN:  state_q <= LN_OFF;
                LN_OFF: begin
                    if (want_s && (peer_off_s || force_rise)) begin
                        state_q <= LN_WAIT;
                        cnt_q   <= '0;
                    end
                end
                LN_WAIT: begin
                    if (!want_s)                state_q <= LN_OFF;
                    else if (cnt_q == CNT_LAST) state_q <= LN_ACTIVE;
                    else                        cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= LN_OFF;
            endcase
        end
    end

    // gate enable changes only while the clock is low
    always_ff @(negedge clk) en_q <= (state_q == LN_ACTIVE);

    assign en_o    = en_q;
    assign off_o   = (state_q == LN_OFF);
    assign claim_o = (state_q == LN_WAIT) || (state_q == LN_ACTIVE);

    // R3
    drain_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_DRAIN && run_s) |=> (state_q == LN_OFF));

    // R4
    wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_WAIT && cnt_q == CNT_LAST && run_s && want_s) |=> (state_q == LN_ACTIVE));

    // R2
    en_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> (state_q == LN_ACTIVE || state_q == LN_DRAIN));

    // R6
    force_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_OFF && run_s && want_s && force_rise) |=> (state_q == LN_WAIT));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s |=> $stable(state_q));
endmodule

// File: rtl/clksw_outdrv.sv
`timescale 1ns/1ps
// One output channel: applies power-down and park overrides to the
// switched clock and forms the true/complement pair.
// Assumes: overrides are asynchronous by intent; runts caused by
// toggling gate or pwr_on are the user's concern.
module clksw_outdrv (
    input  logic clk_mux,
    input  logic gate,
    input  logic park_hi,
    input  logic pwr_on,
    output logic q_t,
    output logic q_c
);
    // priority: power-down, then park, then the live clock
    always_comb begin
        if (!pwr_on) begin
            q_t = 1'b1;
            q_c = 1'b1;
        end else if (gate) begin
            q_t = park_hi;
            q_c = ~park_hi;
        end else begin
            q_t = clk_mux;
            q_c = ~clk_mux;
        end
    end
endmodule

// File: rtl/glitchfree_clk_switch.sv
`timescale 1ns/1ps
// Glitch-free two-source clock switch with per-channel park and power-down.
// Two lanes, each in its own clock domain, hand the output over through
// their synchronized "off" flags. The switched clock is the OR of both
// gated sources. A lane that claims the output while it is the one named
// by src_sel masks the other source, which covers a forced switch away
// from a stopped clock.
// Assumes: src_sel does not toggle while both lanes claim the output.
module glitchfree_clk_switch #(
    parameter int NUM_CH      = 2,
    parameter int LOW_CYC     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_in1,
    input  logic              clk_in2,
    input  logic              rst_n,
    input  logic              src_sel,
    input  logic              force_sel,
    input  logic              pwr_on,
    input  logic              park_hi,
    input  logic [NUM_CH-1:0] gate,
    output logic [NUM_CH-1:0] q_true,
    output logic [NUM_CH-1:0] q_comp
);
    logic off_1, off_2, claim_1, claim_2, en_1, en_2;
    logic eff_1, eff_2, clk_mux;

    clksw_lane #(.LOW_CYC(LOW_CYC), .SYNC_STAGES(SYNC_STAGES), .SEL_VAL(1'b1)) u_lane1 (
        .clk         (clk_in1),
        .rst_n       (rst_n),
        .sel_in      (src_sel),
        .force_in    (force_sel),
        .run_in      (pwr_on),
        .peer_off_in (off_2),
        .off_o       (off_1),
        .claim_o     (claim_1),
        .en_o        (en_1)
    );

    clksw_lane #(.LOW_CYC(LOW_CYC), .SYNC_STAGES(SYNC_STAGES), .SEL_VAL(1'b0)) u_lane2 (
        .clk         (clk_in2),
        .rst_n       (rst_n),
        .sel_in      (src_sel),
        .force_in    (force_sel),
        .run_in      (pwr_on),
        .peer_off_in (off_1),
        .off_o       (off_2),
        .claim_o     (claim_2),
        .en_o        (en_2)
    );

    // mask a source once the selected peer lane has claimed the output
    assign eff_1   = en_1 & ~(claim_2 & ~src_sel);
    assign eff_2   = en_2 & ~(claim_1 &  src_sel);
    assign clk_mux = (clk_in1 & eff_1) | (clk_in2 & eff_2);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        clksw_outdrv u_drv (
            .clk_mux (clk_mux),
            .gate    (gate[c]),
            .park_hi (park_hi),
            .pwr_on  (pwr_on),
            .q_t     (q_true[c]),
            .q_c     (q_comp[c])
        );
    end

    // R2
    one_source_chk: assert property (@(posedge clk_in1) disable iff (!rst_n)
        $onehot0({eff_1, eff_2}));
endmodule

// File: tb/glitchfree_clk_switch_bench.sv
`timescale 1ns/1ps
module glitchfree_clk_switch_bench;
    localparam int  LOW_CYC  = 3;
    localparam int  SYNC     = 2;
    localparam real T1       = 10.0;
    localparam real T2       = 14.0;
    localparam real MIN_HALF = 5.0;
    // each step: {src_sel, expect clk_in1, switch expected}
    localparam logic [2:0] STEPS [8] = '{3'b001, 3'b111, 3'b110, 3'b001,
                                         3'b000, 3'b111, 3'b001, 3'b111};

    logic clk1 = 1'b0, clk2 = 1'b0;
    bit   run1 = 1'b1;
    logic rst_n, src_sel, force_sel, pwr_on, park_hi;
    logic [1:0] gate, q_true, q_comp;
    int   checks = 0, fails = 0, runt_cnt = 0;
    bit   mon_en = 0, have_last = 0, done = 0;
    real  last_t = 0.0, max_low = 0.0;

    always #5 if (run1) clk1 = ~clk1;
    always #7 clk2 = ~clk2;

    glitchfree_clk_switch #(.NUM_CH(2), .LOW_CYC(LOW_CYC), .SYNC_STAGES(SYNC)) u_glitchfree_clk_switch (
        .clk_in1 (clk1), .clk_in2 (clk2), .rst_n (rst_n), .src_sel (src_sel),
        .force_sel (force_sel), .pwr_on (pwr_on), .park_hi (park_hi),
        .gate (gate), .q_true (q_true), .q_comp (q_comp)
    );

    // phase-width monitor on channel 0 (R5, R3, R4)
    always @(q_true[0]) begin
        real dur;
        if (mon_en) begin
            if (have_last) begin
                dur = $realtime - last_t;
                if (dur < MIN_HALF - 0.001) runt_cnt++;
                if (q_true[0] && dur > max_low) max_low = dur;
            end
            last_t = $realtime;
            have_last = 1;
        end else begin
            have_last = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
        end
    endtask

    // three cycles of the expected clock on the true and complement pins
    task automatic follows(input int ch, input bit on1, input string req);
        int bad = 0;
        logic [1:0] got = 2'b00, exp_v = 2'b00;
        repeat (3) begin
            if (on1) @(posedge clk1); else @(posedge clk2);
            #1;
            if ({q_true[ch], q_comp[ch]} != 2'b10) begin
                if (bad == 0) begin got = {q_true[ch], q_comp[ch]}; exp_v = 2'b10; end
                bad++;
            end
            if (on1) @(negedge clk1); else @(negedge clk2);
            #1;
            if ({q_true[ch], q_comp[ch]} != 2'b01) begin
                if (bad == 0) begin got = {q_true[ch], q_comp[ch]}; exp_v = 2'b01; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: ch%0d on clk_in%0d true/comp=%b expected %b",
                     req, ch, on1 ? 1 : 2, got, exp_v);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        real t_new, t_old, lo, hi;
        rst_n = 0; src_sel = 1; force_sel = 0; pwr_on = 1; park_hi = 0; gate = 2'b00;

        // R10: reset picks the lane named by src_sel
        #100;
        follows(0, 1'b1, "R10/R9");
        src_sel = 0;
        #100;
        follows(0, 1'b0, "R10/R9");
        src_sel = 1;
        #100;
        rst_n = 1;
        #100;
        mon_en = 1;

        // table walk: select changes, followed clock and low-gap bounds
        for (int i = 0; i < 8; i++) begin
            max_low = 0.0;
            src_sel = STEPS[i][2];
            #400;
            follows(0, STEPS[i][1], "R1/R9");
            t_new = STEPS[i][1] ? T1 : T2;
            t_old = STEPS[i][1] ? T2 : T1;
            if (STEPS[i][0]) begin
                lo = LOW_CYC * t_new;
                hi = (SYNC + 2) * t_old + (SYNC + LOW_CYC + 2) * t_new;
                chk(max_low >= lo - 0.001 && max_low <= hi + 0.001, "R3/R4 low gap ns",
                    int'(max_low), int'(lo));
            end else begin
                chk(max_low <= T2 / 2.0 + 0.001, "R1 no gap without switch ns",
                    int'(max_low), int'(T2 / 2.0));
            end
        end
        chk(runt_cnt == 0, "R2/R5 short phases", runt_cnt, 0);
        mon_en = 0;

        // R6: switch away from a clock stopped high
        @(posedge clk1);
        #1 run1 = 0;
        src_sel = 0;
        #200;
        chk(q_true[0] == 1'b1, "R6 waits without force", int'(q_true[0]), 1);
        force_sel = 1;
        #60;
        force_sel = 0;
        #300;
        follows(0, 1'b0, "R6");
        run1 = 1;
        #300;
        follows(0, 1'b0, "R6 after restart");
        src_sel = 1;
        #400;
        follows(0, 1'b1, "R6 switch back");

        // R7: per-channel park levels
        gate = 2'b01; park_hi = 0;
        #20;
        chk({q_true[0], q_comp[0]} == 2'b01, "R7 park low", int'({q_true[0], q_comp[0]}), 1);
        follows(1, 1'b1, "R7 other channel");
        park_hi = 1;
        #20;
        chk({q_true[0], q_comp[0]} == 2'b10, "R7 park high", int'({q_true[0], q_comp[0]}), 2);
        gate = 2'b00;
        #20;

        // R8: power-down forces ones and freezes selection
        pwr_on = 0;
        #20;
        chk(q_true == 2'b11 && q_comp == 2'b11, "R8 outputs high",
            int'({q_true, q_comp}), 15);
        src_sel = 0;
        #400;
        chk(q_true == 2'b11 && q_comp == 2'b11, "R8 still high",
            int'({q_true, q_comp}), 15);
        src_sel = 1;
        #30;
        pwr_on = 1;
        follows(0, 1'b1, "R8 frozen selection");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule